// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Busy Polling

This block is the bus-facing half of a multi-channel digital potentiometer controller. It oversamples the serial clock and data lines with a fast system clock and recognises start and stop conditions. It receives a fixed-format address byte and an instruction byte. After these it either receives one data byte, sends one read byte, or ends the command. Each byte that it accepts is acknowledged by asserting an open-drain pull-down enable during the ninth clock.

The address byte has no read/write bit. Its upper bits are a fixed device-type code, and its lower bits must match a set of strap pins. While the register bank reports that a nonvolatile write is running, the slave stays silent on its own address. A master can therefore poll for completion by repeating start and address until it sees an acknowledge.

The bank decodes the received instruction and says how many bytes follow it, through a two-bit kind input. The slave samples this input in the cycle where it acknowledges the instruction. Once every expected byte has been exchanged, the slave raises a one-cycle command strobe together with the instruction and the data byte.

Top module: `tws_slave`

## Requirements
- R1: After reset, sda_oe_o is 0 and cmd_valid_o is 0.
- R2: Before the first start condition, clocked bus bits are ignored: no acknowledge and no strobe.
- R3: A start is SDA falling while SCL is high. The first byte after it is sampled MSB first on SCL high. If the byte equals {4'b0101, dev_pins_i}, sda_oe_o is 1 throughout the ninth SCL high phase.
- R4: If the address byte does not match, sda_oe_o stays 0. Later bytes get no acknowledge until a new start.
- R5: A matching address while busy_i is 1 gets no acknowledge and no strobe.
- R6: The instruction byte is acknowledged. If instr_kind_i is 2'b00 or 2'b11 when the instruction is acknowledged, the command ends with a strobe carrying cmd_instr_o equal to the instruction byte.
- R7: If instr_kind_i is 2'b01, a third byte is received and acknowledged. The strobe then carries that byte on cmd_data_o.
- R8: If instr_kind_i is 2'b10, the slave sends rd_data_i MSB first (sda_oe_o = 1 for a 0 bit). It releases SDA in the ninth clock and strobes afterwards.
- R9: A stop condition (SDA rising while SCL is high) before the last byte completes aborts the command. No strobe is raised, SDA is released, and later bits are ignored.
- R10: A repeated start in the middle of a transfer restarts address reception.
- R11: cmd_valid_o is high for exactly one system clock cycle per completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_pins_i | input | ADDR_PIN_W | Strap pins for the low address bits |
| busy_i | input | 1 | Nonvolatile write in progress; suppresses address acknowledge |
| instr_kind_i | input | 2 | Bytes after instruction: 00/11 none, 01 write byte, 10 read byte |
| rd_data_i | input | 8 | Byte sent on a read command |
| cmd_valid_o | output | 1 | One-cycle strobe when a command completes |
| cmd_instr_o | output | 8 | Last received instruction byte |
| cmd_data_o | output | 8 | Last received data byte |

## Verification
On every cycle, the assertions check several timing properties. SDA is released right after any start or stop. The pull-down enable changes only while the synchronised SCL is low. The strobe lasts one cycle and follows an SCL falling edge. The bench scenarios cover the rest: address matching against the pins and the type code, suppression of the acknowledge while busy, the byte count chosen by the kind input, and the bit order of the read byte. They also show that nothing reaches the bank after an aborted or unstarted transfer, because those behaviours depend on whole byte sequences.

// File: rtl/tws_pkg.sv
package tws_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [1:0] {
      PH_ADDR  = 2'd0,
      PH_INSTR = 2'd1,
      PH_DATA  = 2'd2,
      PH_READ  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_READ  = 2'd2,
      KIND_RSVD  = 2'd3
   } kind_e;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tws_cond_detect.sv
module tws_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s_i;
         sda_d <= sda_s_i;
      end
   end

   assign scl_rise_o = scl_s_i & ~scl_d;
   assign scl_fall_o = ~scl_s_i & scl_d;
   assign start_o    = scl_s_i & scl_d & sda_d & ~sda_s_i;
   assign stop_o     = scl_s_i & scl_d & ~sda_d & sda_s_i;
endmodule

// File: rtl/tws_xfer_fsm.sv
module tws_xfer_fsm
   import tws_pkg::*;
#(
   parameter int ADDR_PIN_W = 4,
   parameter logic [BYTE_W-ADDR_PIN_W-1:0] TYPE_CODE = 4'b0101
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_rise_i,
   input  logic                  scl_fall_i,
   input  logic                  start_i,
   input  logic                  stop_i,
   input  logic                  sda_bit_i,
   input  logic [ADDR_PIN_W-1:0] dev_pins_i,
   input  logic                  busy_i,
   input  logic [1:0]            kind_i,
   input  logic [BYTE_W-1:0]     rd_data_i,
   output logic                  sda_oe_o,
   output logic                  strobe_o,
   output logic [BYTE_W-1:0]     instr_o,
   output logic [BYTE_W-1:0]     data_o
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   logic              active, in_ack, oe_q, strobe_q;
   phase_e            phase;
   kind_e             kind_q;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] rx_sr, tx_sr, instr_q, data_q;
   logic              addr_hit;

   assign addr_hit = (rx_sr == {TYPE_CODE, dev_pins_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         in_ack   <= 1'b0;
         oe_q     <= 1'b0;
         strobe_q <= 1'b0;
         phase    <= PH_ADDR;
         kind_q   <= KIND_NONE;
         bitcnt   <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         instr_q  <= '0;
         data_q   <= '0;
      end else begin
         strobe_q <= 1'b0;
         if (start_i) begin
            active <= 1'b1;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            in_ack <= 1'b0;
            oe_q   <= 1'b0;
         end else if (stop_i) begin
            active <= 1'b0;
            bitcnt <= '0;
            in_ack <= 1'b0;
            oe_q   <= 1'b0;
         end else if (active) begin
            if (scl_rise_i && !in_ack && bitcnt < LAST_BIT) begin
               bitcnt <= bitcnt + 1'b1;
               if (phase == PH_READ) tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
               else                  rx_sr <= {rx_sr[BYTE_W-2:0], sda_bit_i};
            end else if (scl_fall_i) begin
               if (in_ack) begin
                  // end of the ninth clock: move to the next byte
                  in_ack <= 1'b0;
                  bitcnt <= '0;
                  oe_q   <= 1'b0;
                  case (phase)
                     PH_ADDR:  phase <= PH_INSTR;
                     PH_INSTR: begin
                        case (kind_q)
                           KIND_WRITE: phase <= PH_DATA;
                           KIND_READ: begin
                              phase <= PH_READ;
                              tx_sr <= rd_data_i;
                              oe_q  <= ~rd_data_i[BYTE_W-1];
                           end
                           default: begin
                              strobe_q <= 1'b1;
                              active   <= 1'b0;
                           end
                        endcase
                     end
                     default: begin
                        strobe_q <= 1'b1;
                        active   <= 1'b0;
                     end
                  endcase
               end else if (bitcnt == LAST_BIT) begin
                  // eighth bit done: enter the acknowledge slot
                  case (phase)
                     PH_ADDR: begin
                        if (addr_hit && !busy_i) begin
                           oe_q   <= 1'b1;
                           in_ack <= 1'b1;
                        end else begin
                           active <= 1'b0;
                        end
                     end
                     PH_INSTR: begin
                        instr_q <= rx_sr;
                        kind_q  <= kind_e'(kind_i);
                        oe_q    <= 1'b1;
                        in_ack  <= 1'b1;
                     end
                     PH_DATA: begin
                        data_q <= rx_sr;
                        oe_q   <= 1'b1;
                        in_ack <= 1'b1;
                     end
                     default: begin
                        oe_q   <= 1'b0;
                        in_ack <= 1'b1;
                     end
                  endcase
               end else if (phase == PH_READ && bitcnt != '0) begin
                  oe_q <= ~tx_sr[BYTE_W-1];
               end
            end
         end
      end
   end

   assign sda_oe_o = oe_q;
   assign strobe_o = strobe_q;
   assign instr_o  = instr_q;
   assign data_o   = data_q;
endmodule

// File: rtl/tws_slave.sv
module tws_slave
   import tws_pkg::*;
#(
   parameter int ADDR_PIN_W  = 4,
   parameter int SYNC_STAGES = 2,
   parameter logic [BYTE_W-ADDR_PIN_W-1:0] TYPE_CODE = 4'b0101
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic [ADDR_PIN_W-1:0] dev_pins_i,
   input  logic                  busy_i,
   input  logic [1:0]            instr_kind_i,
   input  logic [BYTE_W-1:0]     rd_data_i,
   output logic                  cmd_valid_o,
   output logic [BYTE_W-1:0]     cmd_instr_o,
   output logic [BYTE_W-1:0]     cmd_data_o
);
   localparam int NUM_LINES = 2;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (ADDR_PIN_W >= 1 && ADDR_PIN_W < BYTE_W)
         else $error("ADDR_PIN_W out of range");
   end

   logic [NUM_LINES-1:0] raw_lines, sync_lines;
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
      tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .d_i  (raw_lines[g]),
         .q_o  (sync_lines[g])
      );
   end

   assign scl_s = sync_lines[0];
   assign sda_s = sync_lines[1];

   tws_cond_detect u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s_i   (scl_s),
      .sda_s_i   (sda_s),
      .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall),
      .start_o   (start_det),
      .stop_o    (stop_det)
   );

   tws_xfer_fsm #(.ADDR_PIN_W(ADDR_PIN_W), .TYPE_CODE(TYPE_CODE)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise_i(scl_rise),
      .scl_fall_i(scl_fall),
      .start_i   (start_det),
      .stop_i    (stop_det),
      .sda_bit_i (sda_s),
      .dev_pins_i(dev_pins_i),
      .busy_i    (busy_i),
      .kind_i    (instr_kind_i),
      .rd_data_i (rd_data_i),
      .sda_oe_o  (sda_oe_o),
      .strobe_o  (cmd_valid_o),
      .instr_o   (cmd_instr_o),
      .data_o    (cmd_data_o)
   );
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_oe,
   input logic cmd_valid,
   input logic scl_s,
   input logic scl_fall,
   input logic start_det,
   input logic stop_det
);
   // R9: a stop releases the data line on the next cycle
   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R10: a (repeated) start releases the data line on the next cycle
   p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R3: the pull-down changes only while the synchronised clock is low
   p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R11: the command strobe lasts a single cycle
   p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R6: a strobe always follows an SCL falling edge
   p_strobe_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> $past(scl_fall));
endmodule

bind tws_slave tws_slave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_oe   (sda_oe_o),
   .cmd_valid(cmd_valid_o),
   .scl_s    (scl_s),
   .scl_fall (scl_fall),
   .start_det(start_det),
   .stop_det (stop_det)
);

// File: tb/sim_tws_slave.sv
module sim_tws_slave;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic sda_oe;
   logic [3:0] pins = 4'h0;
   logic busy = 1'b0;
   logic [1:0] kind = 2'b00;
   logic [7:0] rdata = 8'h00;
   logic cmd_valid;
   logic [7:0] cmd_instr, cmd_data;
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0, errors = 0, strobes = 0, wide = 0;
   logic [7:0] cap_instr = 8'h00, cap_data = 8'h00;
   logic prev_valid = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tws_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .dev_pins_i(pins), .busy_i(busy),
      .instr_kind_i(kind), .rd_data_i(rdata), .cmd_valid_o(cmd_valid),
      .cmd_instr_o(cmd_instr), .cmd_data_o(cmd_data)
   );

   always @(negedge clk) begin
      if (cmd_valid) begin
         strobes++;
         cap_instr = cmd_instr;
         cap_data  = cmd_data;
      end
      if (cmd_valid && prev_valid) wide++;
      prev_valid = cmd_valid;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(5);
      scl = 1'b1;   wait_clk(5);
      sda_m = 1'b0; wait_clk(5);
      scl = 1'b0;   wait_clk(5);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(5);
      scl = 1'b1;   wait_clk(5);
      sda_m = 1'b1; wait_clk(10);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; wait_clk(5);
         scl = 1'b1;   wait_clk(10);
         scl = 1'b0;   wait_clk(5);
      end
   endtask

   // ninth clock with the master released; returns the slave's pull-down
   task automatic ack_slot(output logic ack);
      sda_m = 1'b1; wait_clk(5);
      scl = 1'b1;   wait_clk(5);
      ack = sda_oe; wait_clk(5);
      scl = 1'b0;   wait_clk(5);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      ack_slot(ack);
   endtask

   task automatic recv_byte(output logic [7:0] b, output logic rel);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wait_clk(5);
         scl = 1'b1;   wait_clk(5);
         b[i] = sda_line; wait_clk(5);
         scl = 1'b0;   wait_clk(5);
      end
      ack_slot(rel);
      rel = ~rel;
   endtask

   // {addr, pins, busy, kind, instr, wdata, rdata, exp_ack}
   localparam int NV = 8;
   localparam logic [39:0] VEC [NV] = '{
      {8'h5A, 4'hA, 1'b0, 2'd0, 8'h13, 8'h00, 8'h00, 1'b1},
      {8'h53, 4'h3, 1'b0, 2'd1, 8'h82, 8'hC5, 8'h00, 1'b1},
      {8'h5F, 4'hF, 1'b0, 2'd2, 8'h94, 8'h00, 8'hA6, 1'b1},
      {8'h57, 4'h6, 1'b0, 2'd0, 8'h11, 8'h00, 8'h00, 1'b0},
      {8'h4A, 4'hA, 1'b0, 2'd0, 8'h11, 8'h00, 8'h00, 1'b0},
      {8'h50, 4'h0, 1'b1, 2'd0, 8'h11, 8'h00, 8'h00, 1'b0},
      {8'h51, 4'h1, 1'b0, 2'd3, 8'h2E, 8'h00, 8'h00, 1'b1},
      {8'h50, 4'h0, 1'b0, 2'd2, 8'hB0, 8'h00, 8'h01, 1'b1}
   };

   initial begin
      logic ack, rel;
      logic [7:0] rb;
      int s0;

      wait_clk(4);
      // R1: reset state
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
      rst_n = 1'b1;
      wait_clk(5);

      // R2: matching byte clocked with no prior start
      pins = 4'h5;
      scl = 1'b0; wait_clk(5);
      send_byte(8'h55, ack);
      chk(ack == 1'b0, "R2 no ack before start", ack, 0);
      send_byte(8'h10, ack);
      chk(ack == 1'b0, "R2 second byte", ack, 0);
      bus_stop();
      chk(strobes == 0, "R2 no strobe", strobes, 0);

      // table of transactions
      for (int v = 0; v < NV; v++) begin
         logic [7:0] a, ins, wd, rdv;
         logic [1:0] k;
         logic eack;
         {a, pins, busy, k, ins, wd, rdv, eack} = VEC[v];
         kind = k; rdata = rdv;
         s0 = strobes;
         bus_start();
         send_byte(a, ack);
         chk(ack == eack, $sformatf("R3/R4/R5 address ack vec %0d", v), ack, eack);
         if (eack) begin
            send_byte(ins, ack);
            chk(ack == 1'b1, $sformatf("R6 instr ack vec %0d", v), ack, 1);
            if (k == 2'd1) begin
               send_byte(wd, ack);
               chk(ack == 1'b1, $sformatf("R7 data ack vec %0d", v), ack, 1);
            end else if (k == 2'd2) begin
               recv_byte(rb, rel);
               chk(rb == rdv, $sformatf("R8 read byte vec %0d", v), rb, rdv);
               chk(rel == 1'b1, $sformatf("R8 release ninth vec %0d", v), rel, 1);
            end
         end else begin
            send_byte(ins, ack);
            chk(ack == 1'b0, $sformatf("R4 idle after miss vec %0d", v), ack, 0);
         end
         bus_stop();
         busy = 1'b0;
         chk(strobes - s0 == int'(eack), $sformatf("R6 strobe count vec %0d", v),
             strobes - s0, int'(eack));
         if (eack) begin
            chk(cap_instr == ins, $sformatf("R6 instr vec %0d", v), cap_instr, ins);
            if (k == 2'd1)
               chk(cap_data == wd, $sformatf("R7 data vec %0d", v), cap_data, wd);
         end
      end

      // R9: stop in the middle of the instruction byte
      pins = 4'h2; kind = 2'd0; s0 = strobes;
      bus_start();
      send_byte(8'h52, ack);
      chk(ack == 1'b1, "R9 address ack", ack, 1);
      send_bits(8'h3C, 4);
      bus_stop();
      chk(strobes == s0, "R9 abort mid instr", strobes - s0, 0);
      chk(sda_oe == 1'b0, "R9 released", sda_oe, 0);
      scl = 1'b0; wait_clk(5);
      send_byte(8'h3C, ack);
      chk(ack == 1'b0, "R9 ignored after abort", ack, 0);
      bus_stop();

      // R9: stop before the data byte of a write
      kind = 2'd1; s0 = strobes;
      bus_start();
      send_byte(8'h52, ack);
      send_byte(8'h77, ack);
      chk(ack == 1'b1, "R9 write instr ack", ack, 1);
      bus_stop();
      chk(strobes == s0, "R9 abort before data", strobes - s0, 0);

      // R10: repeated start after the address
      kind = 2'd0; s0 = strobes;
      bus_start();
      send_byte(8'h52, ack);
      bus_start();
      send_byte(8'h52, ack);
      chk(ack == 1'b1, "R10 address after repeated start", ack, 1);
      send_byte(8'h6D, ack);
      chk(ack == 1'b1, "R10 instr ack", ack, 1);
      bus_stop();
      chk(strobes - s0 == 1, "R10 one strobe", strobes - s0, 1);
      chk(cap_instr == 8'h6D, "R10 instr value", cap_instr, 8'h6D);

      // R5: busy polling, released later on the same pins
      busy = 1'b1;
      bus_start();
      send_byte(8'h52, ack);
      chk(ack == 1'b0, "R5 busy poll no ack", ack, 0);
      busy = 1'b0;
      bus_start();
      send_byte(8'h52, ack);
      chk(ack == 1'b1, "R5 poll ack after busy clears", ack, 1);
      bus_stop();

      // R11
      chk(wide == 0, "R11 strobe width", wide, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule